// File: doc/BRIEF.md
# Virtual Interrupt List Register Controller

This block holds the list of virtual interrupts that a hypervisor presents to one guest processor. It also carries out the guest's end-of-interrupt and deactivate traffic against that list. The hypervisor loads entries, one at a time, through a 32-bit write port. Each entry holds a virtual ID, a physical ID, a hardware-link flag and a two-bit state. The hypervisor can read back any entry at any time.

The guest side has three operations: acknowledge, end-of-interrupt and deactivate. An acknowledge takes the lowest-numbered pending entry and returns its virtual ID. A deactivation looks up the named ID among the live entries and retires the entry it finds. When that entry is hardware-linked, the block also sends a one-cycle deactivate request for the physical ID. When no entry matches, the block counts the miss, and the count can raise a maintenance interrupt toward the hypervisor.

Priority arbitration, the distributor and bus timing are outside this block.

Top module: `vlr_ctrl`

## Requirements
- R1: After reset, every entry reads 0 (state invalid), the miss count is 0, `maint_irq` and `phys_deact_vld` are 0, and `gst_ack_id` is 1023.
- R2: Entry layout, for both write and read. Bit 31 is the hardware-link flag. Bits 29:28 are the state (00 invalid, 01 pending, 10 active). Bits 19:10 are the physical ID and bits 9:0 the virtual ID. All other bits read 0. A write takes effect on the next clock edge.
- R3: `gst_ack_id` combinationally shows the virtual ID of the lowest-indexed entry in state 01, or 1023 when no entry is pending. On a `gst_ack` cycle, that entry moves to state 10.
- R4: Control bit 2 is the end-of-interrupt mode. When it is 0, a `gst_eoi` is a deactivation. A deactivation moves the lowest-indexed entry whose state is nonzero and whose virtual ID equals `gst_id` to state 00.
- R5: When the mode bit is 1, `gst_eoi` changes no entry and no count. A `gst_dir` is a deactivation in either mode.
- R6: When a deactivation hits an entry with bit 31 set, `phys_deact_vld` pulses for exactly the next cycle, with `phys_deact_id` equal to that entry's physical ID. A hit on an unlinked entry produces no pulse.
- R7: A deactivation that hits no entry increments `eoi_cnt`, saturating at its maximum (31 by default). A deactivation that hits an entry leaves `eoi_cnt` unchanged.
- R8: `maint_irq` = global enable (control bit 0) AND not-present enable (control bit 1) AND (`eoi_cnt` != 0). When the global enable is 0, the output is forced low.
- R9: A control write loads the three control bits and clears `eoi_cnt`. This clear wins over a miss in the same cycle.
- R10: Within one cycle, a hypervisor write to an entry takes priority over a deactivation of it, and a deactivation takes priority over an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hyp_lr_we | input | 1 | Entry write strobe |
| hyp_lr_widx | input | 2 | Entry index to write |
| hyp_lr_wdata | input | 32 | Entry write value |
| hyp_lr_ridx | input | 2 | Entry index to read |
| hyp_lr_rdata | output | 32 | Read value of the indexed entry |
| hyp_ctl_we | input | 1 | Control write strobe |
| hyp_ctl_wdata | input | 3 | Control: bit0 global enable, bit1 not-present enable, bit2 eoi mode |
| gst_ack | input | 1 | Guest acknowledge |
| gst_ack_id | output | 10 | Acknowledged virtual ID, or 1023 |
| gst_eoi | input | 1 | Guest end-of-interrupt write |
| gst_dir | input | 1 | Guest deactivate write |
| gst_id | input | 10 | Virtual ID named by eoi or deactivate |
| phys_deact_vld | output | 1 | Physical deactivate request pulse |
| phys_deact_id | output | 10 | Physical ID being deactivated |
| eoi_cnt | output | 5 | Count of deactivations that hit no entry |
| maint_irq | output | 1 | Maintenance interrupt |

## Verification
A stale or wrong entry state shows at the ports in two places. It appears on `gst_ack_id` in the same cycle, because the pending search is combinational. It also appears in the read-back word one edge after the operation that should have changed it. A broken ID match shows one cycle after the deactivation: either a missing or spurious physical pulse, or a step in `eoi_cnt` that should not be there. The reference model recomputes every output each cycle, so any such divergence is caught within a single clock of the cause.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

  typedef logic [1:0] lr_st_t;
  localparam lr_st_t ST_INV  = 2'b00;
  localparam lr_st_t ST_PEND = 2'b01;
  localparam lr_st_t ST_ACT  = 2'b10;

  typedef struct packed {
    logic            hw;
    lr_st_t          st;
    logic [ID_W-1:0] pid;
    logic [ID_W-1:0] vid;
  } lr_t;

  // word layout: 31 hw, 29:28 state, 19:10 physical id, 9:0 virtual id
  function automatic lr_t lr_unpack(input logic [31:0] w);
    lr_t e;
    e.hw  = w[31];
    e.st  = w[29:28];
    e.pid = w[19:10];
    e.vid = w[9:0];
    return e;
  endfunction

  function automatic logic [31:0] lr_pack(input lr_t e);
    return {e.hw, 1'b0, e.st, 8'h00, e.pid, e.vid};
  endfunction

  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
    return (v == maxv) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/vlr_first.sv
module vlr_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |hit;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vlr_ctrl.sv
module vlr_ctrl #(
  parameter int N_LR  = 4,
  parameter int CNT_W = 5,
  localparam int IW   = (N_LR > 1) ? $clog2(N_LR) : 1,
  localparam int ID_W = vlr_pkg::ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hyp_lr_we,
  input  logic [IW-1:0]    hyp_lr_widx,
  input  logic [31:0]      hyp_lr_wdata,
  input  logic [IW-1:0]    hyp_lr_ridx,
  output logic [31:0]      hyp_lr_rdata,
  input  logic             hyp_ctl_we,
  input  logic [2:0]       hyp_ctl_wdata,
  input  logic             gst_ack,
  output logic [ID_W-1:0]  gst_ack_id,
  input  logic             gst_eoi,
  input  logic             gst_dir,
  input  logic [ID_W-1:0]  gst_id,
  output logic             phys_deact_vld,
  output logic [ID_W-1:0]  phys_deact_id,
  output logic [CNT_W-1:0] eoi_cnt,
  output logic             maint_irq
);
  import vlr_pkg::*;

  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  lr_t lr_q [N_LR];
  logic ctl_en, ctl_npie, ctl_eoi_mode;

  logic [N_LR-1:0] match_vec, pend_vec;
  logic            match_found, pend_found;
  logic [IW-1:0]   match_idx, pend_idx;

  // named internal events for the checker
  logic ev_deact, ev_nomatch, ev_hw_deact;

  for (genvar g = 0; g < N_LR; g++) begin : g_vec
    assign match_vec[g] = (lr_q[g].st != ST_INV) && (lr_q[g].vid == gst_id);
    assign pend_vec[g]  = (lr_q[g].st == ST_PEND);
  end

  vlr_first #(.N(N_LR)) u_match (.hit(match_vec), .found(match_found), .idx(match_idx));
  vlr_first #(.N(N_LR)) u_pend  (.hit(pend_vec),  .found(pend_found),  .idx(pend_idx));

  assign ev_deact    = gst_dir | (gst_eoi & ~ctl_eoi_mode);
  assign ev_nomatch  = ev_deact & ~match_found;
  assign ev_hw_deact = ev_deact & match_found & lr_q[match_idx].hw;

  assign gst_ack_id   = pend_found ? lr_q[pend_idx].vid : SPUR_ID;
  assign hyp_lr_rdata = lr_pack(lr_q[hyp_lr_ridx]);
  assign maint_irq    = ctl_en & ctl_npie & (eoi_cnt != '0);

  for (genvar g = 0; g < N_LR; g++) begin : g_lr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lr_q[g] <= '0;
      end else if (hyp_lr_we && hyp_lr_widx == IW'(g)) begin
        lr_q[g] <= lr_unpack(hyp_lr_wdata);
      end else if (ev_deact && match_found && match_idx == IW'(g)) begin
        lr_q[g].st <= ST_INV;
      end else if (gst_ack && pend_found && pend_idx == IW'(g)) begin
        lr_q[g].st <= ST_ACT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en       <= 1'b0;
      ctl_npie     <= 1'b0;
      ctl_eoi_mode <= 1'b0;
      eoi_cnt      <= '0;
    end else begin
      if (hyp_ctl_we) begin
        ctl_en       <= hyp_ctl_wdata[0];
        ctl_npie     <= hyp_ctl_wdata[1];
        ctl_eoi_mode <= hyp_ctl_wdata[2];
        eoi_cnt      <= '0;
      end else if (ev_nomatch) begin
        eoi_cnt <= CNT_W'(sat_inc(32'(eoi_cnt), CNT_MAX));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_deact_vld <= 1'b0;
      phys_deact_id  <= '0;
    end else begin
      phys_deact_vld <= ev_hw_deact;
      if (ev_hw_deact) phys_deact_id <= lr_q[match_idx].pid;
    end
  end
endmodule

// File: rtl/vlr_ctrl_chk.sv
module vlr_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             ctl_npie,
  input logic             ev_deact,
  input logic             ev_nomatch,
  input logic             ev_hw_deact,
  input logic             match_found,
  input logic             hyp_ctl_we,
  input logic [CNT_W-1:0] eoi_cnt,
  input logic             maint_irq,
  input logic             phys_deact_vld
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_MAINT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    maint_irq |-> (ctl_en && ctl_npie)); // R8
  AST_MAINT_NEEDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    maint_irq |-> (eoi_cnt != '0)); // R8
  AST_PDEACT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    phys_deact_vld |-> $past(ev_hw_deact)); // R6
  AST_CNT_HOLD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_deact && match_found && !hyp_ctl_we) |=> $stable(eoi_cnt)); // R7
  AST_CNT_STEP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nomatch && !hyp_ctl_we && eoi_cnt != CMAX) |=> (eoi_cnt == $past(eoi_cnt) + 1'b1)); // R7
  AST_CTL_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_ctl_we |=> (eoi_cnt == '0)); // R9
endmodule

bind vlr_ctrl vlr_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_vlr_ctrl.sv
module test_vlr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lr_we = 0;
  logic [1:0]  lr_widx = 0, lr_ridx = 0;
  logic [31:0] lr_wdata = 0, rdata;
  logic        ctl_we = 0;
  logic [2:0]  ctl_wd = 0;
  logic        ack = 0, eoi = 0, dir = 0;
  logic [9:0]  gid = 0, ack_id, pd_id;
  logic        pd_vld, maint;
  logic [4:0]  cnt;

  int n_cmp = 0, n_bad = 0;

  vlr_ctrl i_vlr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hyp_lr_we(lr_we), .hyp_lr_widx(lr_widx), .hyp_lr_wdata(lr_wdata),
    .hyp_lr_ridx(lr_ridx), .hyp_lr_rdata(rdata),
    .hyp_ctl_we(ctl_we), .hyp_ctl_wdata(ctl_wd),
    .gst_ack(ack), .gst_ack_id(ack_id),
    .gst_eoi(eoi), .gst_dir(dir), .gst_id(gid),
    .phys_deact_vld(pd_vld), .phys_deact_id(pd_id),
    .eoi_cnt(cnt), .maint_irq(maint)
  );

  // behavioural reference model
  int m_hw[4], m_st[4], m_pid[4], m_vid[4];
  int m_cnt = 0, m_en = 0, m_npie = 0, m_mode = 0, m_pv = 0, m_pid_out = 0;

  function automatic int m_find_pend();
    for (int i = 0; i < 4; i++) if (m_st[i] == 1) return i;
    return -1;
  endfunction

  function automatic int m_find_id(int id);
    for (int i = 0; i < 4; i++) if (m_st[i] != 0 && m_vid[i] == id) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_hw[i] = 0; m_st[i] = 0; m_pid[i] = 0; m_vid[i] = 0; end
      m_cnt = 0; m_en = 0; m_npie = 0; m_mode = 0; m_pv = 0;
    end else begin
      int p, h;
      bit dz;
      p  = m_find_pend();
      h  = m_find_id(int'(gid));
      dz = dir || (eoi && m_mode == 0);
      m_pv = (dz && h >= 0 && m_hw[h] == 1) ? 1 : 0;
      if (m_pv == 1) m_pid_out = m_pid[h];
      if (ctl_we) m_cnt = 0;
      else if (dz && h < 0 && m_cnt < 31) m_cnt = m_cnt + 1;
      if (ack && p >= 0) m_st[p] = 2;
      if (dz && h >= 0) m_st[h] = 0;
      if (lr_we) begin
        m_hw[lr_widx]  = int'(lr_wdata[31]);
        m_st[lr_widx]  = int'(lr_wdata[29:28]);
        m_pid[lr_widx] = int'(lr_wdata[19:10]);
        m_vid[lr_widx] = int'(lr_wdata[9:0]);
      end
      if (ctl_we) begin m_en = int'(ctl_wd[0]); m_npie = int'(ctl_wd[1]); m_mode = int'(ctl_wd[2]); end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    int p;
    logic [31:0] ew;
    p  = m_find_pend();
    ew = {m_hw[lr_ridx][0], 1'b0, 2'(m_st[lr_ridx]), 8'h00, 10'(m_pid[lr_ridx]), 10'(m_vid[lr_ridx])};
    chk("R2", "rdata", int'(rdata), int'(ew));
    chk("R3", "ack_id", int'(ack_id), (p >= 0) ? m_vid[p] : 1023);
    chk("R6", "pd_vld", int'(pd_vld), m_pv);
    if (m_pv == 1) chk("R6", "pd_id", int'(pd_id), m_pid_out);
    chk("R7", "eoi_cnt", int'(cnt), m_cnt);
    chk("R8", "maint", int'(maint), (m_en == 1 && m_npie == 1 && m_cnt != 0) ? 1 : 0);
  endtask

  task automatic clear_in();
    lr_we = 0; ctl_we = 0; ack = 0; eoi = 0; dir = 0;
  endtask

  task automatic tick();
    #1;
    compare_model();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_lr(int idx, logic [31:0] w);
    clear_in(); lr_we = 1; lr_widx = 2'(idx); lr_wdata = w; tick();
  endtask

  task automatic wr_ctl(logic [2:0] v);
    clear_in(); ctl_we = 1; ctl_wd = v; tick();
  endtask

  task automatic gop(bit a, bit e, bit d, int id);
    clear_in(); ack = a; eoi = e; dir = d; gid = 10'(id); tick();
  endtask

  // look at the outputs with idle inputs
  task automatic settle(int ridx);
    clear_in(); lr_ridx = 2'(ridx); #1;
  endtask

  function automatic logic [31:0] mk(bit hw, int st, int pid, int vid);
    return {hw, 1'b0, 2'(st), 8'h00, 10'(pid), 10'(vid)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    settle(2);
    chk("R1", "reset ack_id", int'(ack_id), 1023);
    chk("R1", "reset rdata", int'(rdata), 0);
    chk("R1", "reset cnt", int'(cnt), 0);
    chk("R1", "reset maint", int'(maint), 0);
    chk("R1", "reset pd_vld", int'(pd_vld), 0);
    rst_n = 1;
    @(negedge clk);

    wr_ctl(3'b011);
    wr_lr(0, mk(1, 1, 27, 27));
    wr_lr(1, mk(0, 1, 0, 40));
    settle(0);
    chk("R2", "rdata lr0", int'(rdata), int'(32'h9000_6C1B));
    chk("R3", "lowest pending", int'(ack_id), 27);
    gop(1, 0, 0, 0);
    settle(0);
    chk("R3", "lr0 active", int'(rdata[29:28]), 2);
    chk("R3", "next pending", int'(ack_id), 40);
    gop(1, 0, 0, 0);
    settle(1);
    chk("R3", "spurious", int'(ack_id), 1023);
    gop(0, 1, 0, 27);
    settle(0);
    chk("R6", "phys pulse", int'(pd_vld), 1);
    chk("R6", "phys id", int'(pd_id), 27);
    chk("R4", "lr0 retired", int'(rdata[29:28]), 0);
    chk("R7", "hit keeps cnt", int'(cnt), 0);
    gop(0, 1, 0, 40);
    settle(1);
    chk("R6", "unlinked no pulse", int'(pd_vld), 0);
    chk("R4", "lr1 retired", int'(rdata[29:28]), 0);
    gop(0, 1, 0, 99);
    settle(0);
    chk("R7", "miss counted", int'(cnt), 1);
    chk("R8", "maint up", int'(maint), 1);
    wr_ctl(3'b010);
    gop(0, 1, 0, 99);
    settle(0);
    chk("R8", "enable low forces off", int'(maint), 0);
    chk("R9", "cnt after clear+miss", int'(cnt), 1);

    wr_ctl(3'b111);
    wr_lr(2, mk(0, 2, 3, 50));
    gop(0, 1, 0, 50);
    settle(2);
    chk("R5", "eoi mode1 no change", int'(rdata[29:28]), 2);
    chk("R5", "eoi mode1 no count", int'(cnt), 0);
    gop(0, 0, 1, 50);
    settle(2);
    chk("R5", "dir retires", int'(rdata[29:28]), 0);

    clear_in(); ctl_we = 1; ctl_wd = 3'b011; dir = 1; gid = 10'd77; tick();
    settle(0);
    chk("R9", "clear beats miss", int'(cnt), 0);

    wr_lr(3, mk(0, 2, 0, 60));
    clear_in(); lr_we = 1; lr_widx = 2'd3; lr_wdata = mk(0, 1, 0, 61); dir = 1; gid = 10'd60; tick();
    settle(3);
    chk("R10", "hyp write wins", int'(rdata), int'(mk(0, 1, 0, 61)));
    chk("R10", "pending visible", int'(ack_id), 61);

    // saturation of the miss counter
    for (int k = 0; k < 34; k++) gop(0, 0, 1, 500);
    settle(0);
    chk("R7", "saturated", int'(cnt), 31);

    // randomized traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int pool[5];
      pool = '{5, 6, 7, 27, 1023};
      clear_in();
      lr_ridx = 2'($urandom % 4);
      if ($urandom % 6 == 0) begin
        lr_we = 1; lr_widx = 2'($urandom % 4);
        lr_wdata = mk(1'($urandom % 2), int'($urandom % 3), int'($urandom % 1024), pool[$urandom % 4]);
      end
      if ($urandom % 40 == 0) begin ctl_we = 1; ctl_wd = 3'($urandom % 8); end
      ack = ($urandom % 3 == 0);
      case ($urandom % 4)
        1: eoi = 1;
        2: dir = 1;
        default: ;
      endcase
      gid = 10'(pool[$urandom % 5]);
      tick();
    end

    clear_in();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule